// File: doc/BRIEF.md
# Data Load/Store Breakpoint Bank

This block is the data-side watchpoint bank of an on-chip debug unit. It holds two independent breakpoints. Each one watches the load and store stream of the core and signals a break when an access matches the breakpoint's conditions. Each breakpoint has a base address with a per-bit don't-care mask, separate enables for loads and stores, and an optional filter on the 8-bit address-space identifier of the running program. It can also compare the data value of each byte lane against a 64-bit value held in a low-word and a high-word register.

A byte-lane mask picks which lanes take part in the value check. A lane is compared only when the access enables that byte and the mask leaves it in. Setting the whole mask to ones makes the breakpoint address-only. A match raises a break request for one cycle and sets a sticky per-breakpoint status bit. Debug software reads and writes every register through a simple synchronous register port, and clears status bits by writing ones.

Top module: `dbrk_bank`

## Requirements
- R1: After reset every breakpoint register reads zero, `brk_req` is 0, and the status word (register address 0) reads 0x0200_0000: bits 1..0 are clear and bits 27..24 give the breakpoint count, 2.
- R2: The register address is {slot[4:3], field[2:0]}. Slot 0 field 0 is status. Slots 1 and 2 are breakpoints 0 and 1, with fields 0 base address, 1 address mask, 2 control, 3 ID, 4 low value, 5 high value. Written values read back. In control only bit 0 (load enable), bit 1 (store enable), bit 2 (ID filter enable) and bits 15..8 (lane mask) are kept.
- R3: A breakpoint matches only during a valid access (`acc_valid`=1) whose type is enabled: `acc_is_store`=0 needs control bit 0, and `acc_is_store`=1 needs control bit 1.
- R4: The address matches when `acc_addr` equals the base in every bit where the address mask is 0. Mask bits set to 1 are excluded.
- R5: Byte lane i is `acc_data[8i+7:8i]`. Lanes 0..3 are compared with the low-value register and lanes 4..7 with the high-value register. A lane takes part only when `acc_be[i]`=1 and lane-mask bit i is 0, and every lane that takes part must be equal.
- R6: A lane mask of 0xFF makes the breakpoint address-only: any data value matches.
- R7: When control bit 2 is set, `cur_id` must equal the breakpoint's 8-bit ID. When it is clear the ID is ignored. The ID register reads with bits 31..8 zero.
- R8: A match sets status bit n on the next clock edge. The bit stays set until a write to the status register with bit n = 1. A match in the same cycle as that clear wins.
- R9: `brk_req` is 1 in the cycle after any breakpoint matched, and 0 in the cycle after a cycle with no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A load or store is presented this cycle |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access address |
| acc_be | input | 8 | Byte enables of the 64-bit data path |
| acc_data | input | 64 | Load or store data |
| cur_id | input | 8 | Address-space ID of the running program |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address {slot, field} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| brk_req | output | 1 | Break request, one cycle after a match |
| hit_status | output | 2 | Sticky matched-breakpoint bits |

## Verification
The assertions assume `reg_addr` and `reg_wdata` are stable whenever `reg_we` is high. They also assume register writes are never used to reach an unimplemented slot when the sticky-hold property is read. The status properties assume that the only way to clear a bit is a status write with that bit set. The bench changes every input only on the falling clock edge and holds each access for exactly one cycle. It clears status before each table vector, so every expected status comes from that vector alone.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  localparam int REG_W  = 32;
  localparam int DATA_W = 64;
  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int ID_W   = 8;
  localparam int FLD_W  = 3;

  localparam logic [FLD_W-1:0] FLD_BASE = 3'd0;
  localparam logic [FLD_W-1:0] FLD_MASK = 3'd1;
  localparam logic [FLD_W-1:0] FLD_CTRL = 3'd2;
  localparam logic [FLD_W-1:0] FLD_ID   = 3'd3;
  localparam logic [FLD_W-1:0] FLD_VLO  = 3'd4;
  localparam logic [FLD_W-1:0] FLD_VHI  = 3'd5;
  localparam logic [FLD_W-1:0] FLD_STAT = 3'd0;

  localparam int CTL_LD  = 0;
  localparam int CTL_ST  = 1;
  localparam int CTL_IDU = 2;
  localparam int CTL_LM  = 8;
  localparam int CNT_LSB = 24;
  localparam int CNT_W   = 4;

  // address equality with don't-care bits
  function automatic logic addr_equal(input logic [REG_W-1:0] a,
                                      input logic [REG_W-1:0] base,
                                      input logic [REG_W-1:0] dc);
    return ((a ^ base) & ~dc) == '0;
  endfunction

  // every enabled and unmasked byte lane must agree
  function automatic logic lanes_equal(input logic [DATA_W-1:0] d,
                                       input logic [DATA_W-1:0] v,
                                       input logic [LANES-1:0]  be,
                                       input logic [LANES-1:0]  lm);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (be[i] && !lm[i] && (d[i*BYTE_W +: BYTE_W] != v[i*BYTE_W +: BYTE_W]))
        ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/dbrk_slot.sv
module dbrk_slot
  import dbrk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLD_W-1:0]  wr_field,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [FLD_W-1:0]  rd_field,
  output logic [REG_W-1:0]  rd_data,
  input  logic              acc_valid,
  input  logic              acc_is_store,
  input  logic [REG_W-1:0]  acc_addr,
  input  logic [LANES-1:0]  acc_be,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [ID_W-1:0]   cur_id,
  output logic              hit,
  output logic              addr_eq,
  output logic              lane_eq
);
  localparam int HALF = DATA_W / 2;

  logic [REG_W-1:0] base_q, dc_q;
  logic [HALF-1:0]  vlo_q, vhi_q;
  logic [ID_W-1:0]  id_q;
  logic [LANES-1:0] lm_q;
  logic             ld_en_q, st_en_q, idu_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      dc_q    <= '0;
      vlo_q   <= '0;
      vhi_q   <= '0;
      id_q    <= '0;
      lm_q    <= '0;
      ld_en_q <= 1'b0;
      st_en_q <= 1'b0;
      idu_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_field)
        FLD_BASE: base_q <= wr_data;
        FLD_MASK: dc_q   <= wr_data;
        FLD_CTRL: begin
          ld_en_q <= wr_data[CTL_LD];
          st_en_q <= wr_data[CTL_ST];
          idu_q   <= wr_data[CTL_IDU];
          lm_q    <= wr_data[CTL_LM +: LANES];
        end
        FLD_ID:   id_q  <= wr_data[ID_W-1:0];
        FLD_VLO:  vlo_q <= wr_data[HALF-1:0];
        FLD_VHI:  vhi_q <= wr_data[HALF-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_field)
      FLD_BASE: rd_data = base_q;
      FLD_MASK: rd_data = dc_q;
      FLD_CTRL: begin
        rd_data[CTL_LD]        = ld_en_q;
        rd_data[CTL_ST]        = st_en_q;
        rd_data[CTL_IDU]       = idu_q;
        rd_data[CTL_LM +: LANES] = lm_q;
      end
      FLD_ID:  rd_data[ID_W-1:0] = id_q;
      FLD_VLO: rd_data[HALF-1:0] = vlo_q;
      FLD_VHI: rd_data[HALF-1:0] = vhi_q;
      default: rd_data = '0;
    endcase
  end

  logic type_ok, id_ok;
  assign type_ok = acc_is_store ? st_en_q : ld_en_q;
  assign id_ok   = !idu_q || (id_q == cur_id);
  assign addr_eq = addr_equal(acc_addr, base_q, dc_q);
  assign lane_eq = lanes_equal(acc_data, {vhi_q, vlo_q}, acc_be, lm_q);
  assign hit     = acc_valid && type_ok && id_ok && addr_eq && lane_eq;
endmodule

// File: rtl/dbrk_status.sv
module dbrk_status #(
  parameter int NUM_BP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_BP-1:0] set_vec,
  input  logic              clr_en,
  input  logic [NUM_BP-1:0] clr_vec,
  output logic [NUM_BP-1:0] sticky
);
  logic [NUM_BP-1:0] drop;
  assign drop = clr_en ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~drop) | set_vec;
  end
endmodule

// File: rtl/dbrk_bank.sv
module dbrk_bank
  import dbrk_pkg::*;
#(
  parameter int NUM_BP = 2,
  parameter int SLOT_W = $clog2(NUM_BP + 1),
  parameter int RAW    = SLOT_W + FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_is_store,
  input  logic [REG_W-1:0]  acc_addr,
  input  logic [LANES-1:0]  acc_be,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [ID_W-1:0]   cur_id,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              brk_req,
  output logic [NUM_BP-1:0] hit_status
);
  logic [SLOT_W-1:0] sel_slot;
  logic [FLD_W-1:0]  sel_field;
  assign sel_slot  = reg_addr[RAW-1:FLD_W];
  assign sel_field = reg_addr[FLD_W-1:0];

  logic [NUM_BP-1:0] slot_hit, addr_eq, lane_eq;
  logic [REG_W-1:0]  slot_rd [NUM_BP];

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    logic wr_sel;
    assign wr_sel = reg_we && (sel_slot == SLOT_W'(g + 1));
    dbrk_slot u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_sel),
      .wr_field     (sel_field),
      .wr_data      (reg_wdata),
      .rd_field     (sel_field),
      .rd_data      (slot_rd[g]),
      .acc_valid    (acc_valid),
      .acc_is_store (acc_is_store),
      .acc_addr     (acc_addr),
      .acc_be       (acc_be),
      .acc_data     (acc_data),
      .cur_id       (cur_id),
      .hit          (slot_hit[g]),
      .addr_eq      (addr_eq[g]),
      .lane_eq      (lane_eq[g])
    );
  end

  logic clr_en;
  assign clr_en = reg_we && (sel_slot == '0) && (sel_field == FLD_STAT);

  dbrk_status #(.NUM_BP(NUM_BP)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (slot_hit),
    .clr_en  (clr_en),
    .clr_vec (reg_wdata[NUM_BP-1:0]),
    .sticky  (hit_status)
  );

  logic [REG_W-1:0] status_word;
  always_comb begin
    status_word = '0;
    status_word[CNT_LSB +: CNT_W] = CNT_W'(NUM_BP);
    status_word[NUM_BP-1:0]       = hit_status;
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_slot == '0) begin
      if (sel_field == FLD_STAT) reg_rdata = status_word;
    end else begin
      for (int i = 0; i < NUM_BP; i++)
        if (sel_slot == SLOT_W'(i + 1)) reg_rdata = slot_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) brk_req <= 1'b0;
    else        brk_req <= |slot_hit;
  end
endmodule

// File: rtl/dbrk_chk.sv
module dbrk_chk #(
  parameter int NUM_BP = 2,
  parameter int RAW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              reg_we,
  input logic [RAW-1:0]    reg_addr,
  input logic [NUM_BP-1:0] clr_bits,
  input logic [3:0]        rd_cnt,
  input logic [23:0]       rd_upper,
  input logic              brk_req,
  input logic [NUM_BP-1:0] hit_status,
  input logic [NUM_BP-1:0] slot_hit,
  input logic [NUM_BP-1:0] addr_eq,
  input logic [NUM_BP-1:0] lane_eq
);
  AST_COUNT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RAW'(0)) |-> (rd_cnt == 4'(NUM_BP))); // R1
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (slot_hit == '0)); // R3
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr[2:0] == 3'd3) && (reg_addr[RAW-1:3] != '0)) |-> (rd_upper == '0)); // R7
  AST_REQ_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_hit) |=> brk_req); // R9
  AST_REQ_ONLY_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(|slot_hit) |=> !brk_req); // R9

  for (genvar g = 0; g < NUM_BP; g++) begin : g_chk
    AST_HIT_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hit[g] |-> addr_eq[g]); // R4
    AST_HIT_NEEDS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hit[g] |-> lane_eq[g]); // R5
    AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hit[g] |=> hit_status[g]); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_status[g] && !(reg_we && (reg_addr == RAW'(0)) && clr_bits[g])) |=> hit_status[g]); // R8
  end
endmodule

bind dbrk_bank dbrk_chk #(.NUM_BP(NUM_BP), .RAW(RAW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .clr_bits   (reg_wdata[NUM_BP-1:0]),
  .rd_cnt     (reg_rdata[27:24]),
  .rd_upper   (reg_rdata[31:8]),
  .brk_req    (brk_req),
  .hit_status (hit_status),
  .slot_hit   (slot_hit),
  .addr_eq    (addr_eq),
  .lane_eq    (lane_eq)
);

// File: tb/test_dbrk_bank.sv
module test_dbrk_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_is_store = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [7:0]  acc_be = '0;
  logic [63:0] acc_data = '0;
  logic [7:0]  cur_id = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        brk_req;
  logic [1:0]  hit_status;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbrk_bank i_dbrk_bank (.*);

  // register addresses: {slot, field}
  localparam logic [4:0] A_STAT = 5'd0;
  localparam logic [4:0] B0 = 5'd8, B1 = 5'd16;

  typedef struct packed {
    logic        st;
    logic [31:0] addr;
    logic [7:0]  be;
    logic [63:0] data;
    logic [7:0]  id;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h1000_0048, 8'hFF, 64'h5566_7788_1122_3344, 8'h00, 2'b01}, // masked low nibble
    '{1'b0, 32'h1000_0050, 8'hFF, 64'h5566_7788_1122_3344, 8'h00, 2'b00}, // bit 4 differs
    '{1'b0, 32'h1000_0040, 8'h0F, 64'hDEAD_BEEF_1122_3344, 8'h00, 2'b01}, // upper lanes off
    '{1'b0, 32'h1000_0040, 8'hFF, 64'hDEAD_BEEF_1122_3344, 8'h00, 2'b00}, // upper mismatch
    '{1'b1, 32'h2000_00AB, 8'h01, 64'h0123_4567_89AB_CDEF, 8'h5A, 2'b10}, // address only, id ok
    '{1'b1, 32'h2000_00AB, 8'h01, 64'h0123_4567_89AB_CDEF, 8'h5B, 2'b00}, // id mismatch
    '{1'b0, 32'h2000_00AB, 8'h01, 64'h0123_4567_89AB_CDEF, 8'h5A, 2'b00}, // load not enabled
    '{1'b1, 32'h1000_0044, 8'hF0, 64'h5566_7788_0000_0000, 8'h00, 2'b01}, // high word match
    '{1'b1, 32'h1000_0040, 8'hF0, 64'h5566_7789_0000_0000, 8'h00, 2'b00}  // lane 4 differs
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = A_STAT; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = A_STAT;
  endtask

  // one-cycle access; on return it is the negedge after the capturing edge
  task automatic access(input logic st, input logic [31:0] a, input logic [7:0] be,
                        input logic [63:0] d, input logic [7:0] id);
    @(negedge clk);
    acc_valid = 1'b1; acc_is_store = st; acc_addr = a; acc_be = be; acc_data = d; cur_id = id;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 brk_req after reset", {31'b0, brk_req}, 32'h0);
    rd(A_STAT, r); check("R1 status word", r, 32'h0200_0000);
    rd(B0 + 5'd2, r); check("R1 ctrl0 reset", r, 32'h0);
    rd(B1 + 5'd5, r); check("R1 vhi1 reset", r, 32'h0);

    // configuration
    wr(B0 + 5'd0, 32'h1000_0040);
    wr(B0 + 5'd1, 32'h0000_000F);
    wr(B0 + 5'd2, 32'hFFFF_0003);   // loads+stores, lane mask 0, reserved bits dropped
    wr(B0 + 5'd4, 32'h1122_3344);
    wr(B0 + 5'd5, 32'h5566_7788);
    wr(B1 + 5'd0, 32'h2000_0000);
    wr(B1 + 5'd1, 32'h0000_00FF);
    wr(B1 + 5'd2, 32'h0000_FF06);   // stores, id filter, lane mask all ones
    wr(B1 + 5'd3, 32'hFFFF_FF5A);

    // R2 readback
    rd(B0 + 5'd2, r); check("R2 ctrl0 readback", r, 32'h0000_0003);
    rd(B0 + 5'd5, r); check("R2 vhi0 readback", r, 32'h5566_7788);
    rd(B1 + 5'd1, r); check("R2 mask1 readback", r, 32'h0000_00FF);
    // R7 id upper bits
    rd(B1 + 5'd3, r); check("R7 id upper zero", r, 32'h0000_005A);

    // table: R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      wr(A_STAT, 32'h3);
      access(VEC[k].st, VEC[k].addr, VEC[k].be, VEC[k].data, VEC[k].id);
      check($sformatf("R9 vec %0d brk_req", k), {31'b0, brk_req}, {31'b0, (VEC[k].exp != 2'b00)});
      check($sformatf("R3-5 vec %0d status", k), {30'b0, hit_status}, {30'b0, VEC[k].exp});
    end

    // R9 one-cycle request; R8 sticky across idle cycles
    wr(A_STAT, 32'h3);
    access(1'b0, 32'h1000_0040, 8'hFF, 64'h5566_7788_1122_3344, 8'h00);
    @(negedge clk);
    check("R9 brk_req drops", {31'b0, brk_req}, 32'h0);
    repeat (3) @(negedge clk);
    rd(A_STAT, r); check("R8 sticky holds", r, 32'h0200_0001);

    // R8 set wins over clear
    @(negedge clk);
    acc_valid = 1'b1; acc_is_store = 1'b0; acc_addr = 32'h1000_0040; acc_be = 8'hFF;
    acc_data = 64'h5566_7788_1122_3344;
    reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h1;
    @(negedge clk);
    acc_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    check("R8 set beats clear", {30'b0, hit_status}, 32'h1);

    // R8 partial write-one clear
    access(1'b1, 32'h2000_0011, 8'h80, 64'h0, 8'h5A);
    check("R8 both set", {30'b0, hit_status}, 32'h3);
    wr(A_STAT, 32'h1);
    check("R8 clear only bit 0", {30'b0, hit_status}, 32'h2);
    wr(A_STAT, 32'h0);
    check("R8 write zero keeps", {30'b0, hit_status}, 32'h2);

    // R5 lane mask excludes high lanes: previously failing vector now hits
    wr(A_STAT, 32'h3);
    wr(B0 + 5'd2, 32'h0000_F001);
    access(1'b0, 32'h1000_0040, 8'hFF, 64'hDEAD_BEEF_1122_3344, 8'h00);
    check("R5 masked lanes excluded", {30'b0, hit_status}, 32'h1);
    // R3 stores now disabled on bp0
    wr(A_STAT, 32'h3);
    access(1'b1, 32'h1000_0040, 8'hFF, 64'h5566_7788_1122_3344, 8'h00);
    check("R3 store disabled", {30'b0, hit_status}, 32'h0);

    // R7 id filter off: mismatching id still hits
    wr(B1 + 5'd2, 32'h0000_FF02);
    access(1'b1, 32'h2000_00AB, 8'h01, 64'h0, 8'hC3);
    check("R7 id ignored when off", {30'b0, hit_status}, 32'h2);

    // R6 address-only with all bytes enabled and arbitrary data
    wr(A_STAT, 32'h3);
    access(1'b1, 32'h2000_00FE, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    check("R6 address only", {30'b0, hit_status}, 32'h2);

    // R3 no access, no change
    wr(A_STAT, 32'h3);
    @(negedge clk);
    acc_addr = 32'h2000_0000; acc_is_store = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 idle no hit", {30'b0, hit_status}, 32'h0);
    check("R9 idle no req", {31'b0, brk_req}, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule